// File: doc/BRIEF.md
# Multiword Scalar Multiply-Accumulate Engine

This block multiplies a long unsigned integer, held as an array of 16-bit words in an input memory, by a single 16-bit scalar. The integer is stored least-significant word first, so word 0 is at address 0 and higher-order words sit at higher addresses. One of three operations is chosen at start: the product can be written into an output array, added to the number already held there, or subtracted from it. The engine walks the words in ascending order, completing one read-modify-write of the output array per clock cycle, and passes a 16-bit carry word from each step to the next.

Every step takes the 32-bit sum of the current input word times the scalar and the carry word. The low half feeds the output word and the high half becomes the next carry. Any carry out of the 16-bit addition, or any borrow out of the 16-bit subtraction, is added to that next carry. Plain multiplication stores the final carry as one extra word just above the number. Accumulation and subtraction do not store it; they return it on a result port, as the carry-out or the borrow-out respectively.

Both memory read ports are asynchronous: the data for an address must be valid in the same cycle as the address. The output array is read and written at one shared address. Control uses plain start, busy and done pins. The memory ports have no valid/ready handshake and no back-pressure, so the engine issues one access per cycle from start to finish and the memories must always be able to accept it. A length of zero is not a legal request.

Top module: `mw_scalar_mac`

## Requirements
- R1: Step i (i = 0, 1, ... len-1) reads input word i and output word i and writes output word i. Steps run in ascending order, one per clock cycle, and the first step uses address 0.
- R2: For mode 2'b00 (plain multiply), output word i receives bits [15:0] of in[i]*k + c. Output word len receives the carry left after the last input word. The result port reads 0 at done.
- R3: For mode 2'b01 (multiply-add), output word i becomes bits [15:0] of out[i] + in[i]*k + c, and the next carry is bits [31:16] of that sum. Output word len is left untouched, and the final carry appears on the result port at done.
- R4: For mode 2'b10 (multiply-subtract), output word i becomes bits [15:0] of out[i] - (in[i]*k + c). The next carry is bits [31:16] of the product-plus-carry plus 1 if that 16-bit subtraction borrowed. Output word len is left untouched, and the final borrow word appears on the result port at done.
- R5: Mode 2'b11 behaves exactly like plain multiply.
- R6: The carry word is cleared when an operation starts, so consecutive operations do not affect each other.
- R7: A start seen while idle raises busy on the next cycle. Busy lasts len cycles, or len+1 in plain multiply. Done then pulses high for exactly one cycle, with busy low and the result valid. Output writes occur only while busy.
- R8: A start pulse, or a change of mode, length or scalar, made while busy or during the done cycle has no effect on the running operation and does not begin a new one.
- R9: Lengths up to 65536 words are handled, including the extra word stored at index 65536 in plain multiply.
- R10: After reset, busy, done, the write enable and the result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 multiply |
| len | input | 17 | Number of input words, 1 to 65536 |
| scalar | input | 16 | Multiplier word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Returned carry or borrow word (0 for multiply) |
| in_addr | output | 17 | Input array word address |
| in_data | input | 16 | Input array read data, same cycle |
| out_addr | output | 17 | Output array word address for read and write |
| out_rdata | input | 16 | Output array read data, same cycle |
| out_we | output | 1 | Output array write enable |
| out_wdata | output | 16 | Output array write data |

## Verification
The assertions assume that start is only a control request and that a length is never zero, so every accepted operation makes at least one step. They also assume the memories answer in the same cycle, which means the address sequence depends only on the control pins. To stay inside these assumptions, the stimulus draws every length from 1 upward, limits the small random cases to a 64-word array, and keeps start pulses off the reset window. Extra start pulses and input changes are deliberately placed in the middle of each operation and in its done cycle, to exercise the ignore rule without breaking the assumptions.

// File: rtl/mwmac_pkg.sv
package mwmac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_MSB  = 2'b10,
    OP_MUL2 = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_FIN
  } st_e;

  function automatic logic op_is_plain(input op_e op);
    return (op == OP_MUL) || (op == OP_MUL2);
  endfunction
endpackage

// File: rtl/mwmac_dp.sv
module mwmac_dp
  import mwmac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          clr,
  input  logic          step,
  input  logic          tail,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] k,
  input  logic [DW-1:0] o,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] nc
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] carry_q;
  logic [PW-1:0] prod_c;
  logic [PW-1:0] acc_sum;
  logic [DW:0]   sub_diff;
  logic [DW-1:0] op_word;

  assign prod_c   = (PW'(x) * PW'(k)) + PW'(carry_q);
  assign acc_sum  = prod_c + PW'(o);
  assign sub_diff = {1'b0, o} - {1'b0, prod_c[DW-1:0]};

  always_comb begin
    op_word = prod_c[DW-1:0];
    nc      = prod_c[PW-1:DW];
    case (op)
      OP_MAC: begin
        op_word = acc_sum[DW-1:0];
        nc      = acc_sum[PW-1:DW];
      end
      OP_MSB: begin
        op_word = sub_diff[DW-1:0];
        nc      = prod_c[PW-1:DW] + DW'(sub_diff[DW]);
      end
      default: ;
    endcase
  end

  assign wdata = tail ? carry_q : op_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= '0;
    else if (clr)  carry_q <= '0;
    else if (step) carry_q <= nc;
  end
endmodule

// File: rtl/mwmac_seq.sv
module mwmac_seq
  import mwmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] len,
  input  logic [DW-1:0] scalar,
  input  logic [DW-1:0] nc,
  output op_e           op_q,
  output logic [DW-1:0] k_q,
  output logic [CW-1:0] idx,
  output logic          clr,
  output logic          step,
  output logic          tail,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  st_e           st;
  logic [CW-1:0] len_q;
  logic          last;

  assign last = (idx == len_q - CW'(1));
  assign clr  = (st == ST_IDLE) && start;
  assign step = (st == ST_RUN);
  assign tail = (st == ST_TAIL);
  assign busy = step || tail;
  assign done = (st == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      len_q  <= '0;
      k_q    <= '0;
      op_q   <= OP_MUL;
      result <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_RUN;
          idx   <= '0;
          len_q <= len;
          k_q   <= scalar;
          op_q  <= op_e'(mode);
        end
        ST_RUN: begin
          idx <= idx + CW'(1);
          if (last) begin
            if (op_is_plain(op_q)) begin
              st <= ST_TAIL;
            end else begin
              st     <= ST_FIN;
              result <= nc;
            end
          end
        end
        ST_TAIL: begin
          st     <= ST_FIN;
          result <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_scalar_mac.sv
module mw_scalar_mac
  import mwmac_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_LEN = 65536,
  localparam int CW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] len,
  input  logic [DW-1:0] scalar,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [CW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [CW-1:0] out_addr,
  input  logic [DW-1:0] out_rdata,
  output logic          out_we,
  output logic [DW-1:0] out_wdata
);
  op_e           op_q;
  logic [DW-1:0] k_q;
  logic [DW-1:0] nc;
  logic [CW-1:0] idx;
  logic          clr, step, tail;

  mwmac_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len(len),
    .scalar(scalar), .nc(nc), .op_q(op_q), .k_q(k_q), .idx(idx),
    .clr(clr), .step(step), .tail(tail), .busy(busy), .done(done),
    .result(result)
  );

  mwmac_dp #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .op(op_q), .clr(clr), .step(step),
    .tail(tail), .x(in_data), .k(k_q), .o(out_rdata),
    .wdata(out_wdata), .nc(nc)
  );

  assign in_addr  = idx;
  assign out_addr = idx;
  assign out_we   = busy;
endmodule

// File: rtl/mwmac_chk.sv
module mwmac_chk #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          out_we,
  input logic [CW-1:0] out_addr,
  input logic [CW-1:0] in_addr
);
  p_first_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_addr == '0) && (in_addr == '0));

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (out_addr == $past(out_addr) + CW'(1)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_write_in_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> busy);

  p_start_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !busy);
endmodule

bind mw_scalar_mac mwmac_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_we(out_we), .out_addr(out_addr), .in_addr(in_addr)
);

// File: tb/mw_scalar_mac_test.sv
module mw_scalar_mac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [16:0] len = 17'd1;
  logic [15:0] scalar = 16'h0;
  logic        busy, done, out_we;
  logic [15:0] result, in_data, out_rdata, out_wdata;
  logic [16:0] in_addr, out_addr;

  int vectors = 0;
  int errors = 0;
  logic [15:0] imem [128];
  logic [15:0] omem [128];
  logic [15:0] emem [128];
  logic [15:0] eres;
  logic        long_run = 1'b0;
  logic [15:0] long_k = 16'h0;
  logic [15:0] long_c = 16'h0;
  int          long_bad = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  mw_scalar_mac uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len(len),
    .scalar(scalar), .busy(busy), .done(done), .result(result),
    .in_addr(in_addr), .in_data(in_data), .out_addr(out_addr),
    .out_rdata(out_rdata), .out_we(out_we), .out_wdata(out_wdata)
  );

  function automatic logic [15:0] hword(input logic [16:0] a);
    logic [31:0] h;
    h = ({15'd0, a} + 32'd7) * 32'h9E3779B1;
    return h[23:8];
  endfunction

  assign in_data   = long_run ? hword(in_addr) : imem[in_addr[6:0]];
  assign out_rdata = omem[out_addr[6:0]];

  always @(posedge clk) begin
    if (out_we && !long_run) omem[out_addr[6:0]] <= out_wdata;
    if (out_we && long_run) begin
      logic [31:0] t;
      logic [15:0] e;
      if (out_addr < 17'd65536) begin
        t = hword(out_addr) * long_k + {16'd0, long_c};
        e = t[15:0];
        long_c = t[31:16];
      end else begin
        e = long_c;
      end
      if (out_wdata !== e) long_bad++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual run length %0d cycles, expected under 190000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements (signed remainder form).
  task automatic model(input logic [1:0] m, input int n, input logic [15:0] k);
    logic [15:0] c;
    longint v;
    c = 16'h0;
    for (int i = 0; i < 128; i++) emem[i] = omem[i];
    for (int i = 0; i < n; i++) begin
      if (m == 2'b01)      v = longint'(omem[i]) + longint'(imem[i]) * longint'(k) + longint'(c);
      else if (m == 2'b10) v = longint'(omem[i]) - longint'(imem[i]) * longint'(k) - longint'(c);
      else                 v = longint'(imem[i]) * longint'(k) + longint'(c);
      emem[i] = v[15:0];
      if (m == 2'b10) c = 16'(-(v >>> 16));
      else            c = 16'(v >>> 16);
    end
    if (m == 2'b01 || m == 2'b10) eres = c;
    else begin
      eres = 16'h0;
      emem[n] = c;
    end
  endtask

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] m, input int n, input logic [15:0] k);
    int cnt;
    int want;
    model(m, n, k);
    want = (m == 2'b01 || m == 2'b10) ? n + 1 : n + 2;
    @(negedge clk);
    mode = m; len = 17'(n); scalar = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7", {31'd0, busy}, 32'd1);
    cnt = 1;
    while (done !== 1'b1 && cnt < 200) begin
      @(negedge clk);
      cnt++;
      // R8: disturb inputs mid-operation
      if (cnt == 2 && n >= 3) begin
        start = 1'b1; mode = ~m; scalar = ~k; len = 17'd2;
      end else begin
        start = 1'b0;
      end
    end
    check(cnt == want, "R7", 32'(cnt), 32'(want));
    check(busy === 1'b0, "R7", {31'd0, busy}, 32'd0);
    check(result === eres, req_of(m), {16'd0, result}, {16'd0, eres});
    // R8: start during the done cycle must be ignored
    start = 1'b1; mode = 2'b00; scalar = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0 && done === 1'b0, "R8", {30'd0, busy, done}, 32'd0);
    for (int i = 0; i < 128; i++)
      if (omem[i] !== emem[i])
        check(1'b0, (i < n) ? req_of(m) : "R8", {16'd0, omem[i]}, {16'd0, emem[i]});
    check(1'b1, req_of(m), 32'd0, 32'd0);
  endtask

  task automatic fill(input logic [15:0] iv, input logic [15:0] ov, input logic rnd);
    for (int i = 0; i < 128; i++) begin
      imem[i] = rnd ? 16'($urandom) : iv;
      omem[i] = rnd ? 16'($urandom) : ov;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill(16'h0, 16'h0, 1'b1);
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy === 1'b0 && done === 1'b0 && out_we === 1'b0 && result === 16'h0,
          "R10", {13'd0, busy, done, out_we}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners: all-ones operands, single words, each mode
    for (int m = 0; m < 4; m++) begin
      fill(16'hFFFF, 16'hFFFF, 1'b0);
      run_op(2'(m), 8, 16'hFFFF);
      fill(16'hFFFF, 16'h0000, 1'b0);
      run_op(2'(m), 1, 16'hFFFF);
    end
    fill(16'h0, 16'h0, 1'b1);
    run_op(2'b10, 5, 16'h0);        // R4: zero scalar, no borrow chain
    fill(16'h0001, 16'h0000, 1'b0);
    run_op(2'b10, 6, 16'h0001);     // R4: borrow ripples through zeros
    // R6: back-to-back ops, carry must not leak
    fill(16'hFFFF, 16'h0, 1'b0);
    run_op(2'b01, 4, 16'hFFFF);
    run_op(2'b01, 4, 16'hFFFF);

    // Constrained random
    for (int t = 0; t < 40; t++) begin
      fill(16'h0, 16'h0, 1'b1);
      run_op(2'($urandom_range(0, 3)), int'($urandom_range(1, 64)),
             ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom));
    end

    // R9: maximum length in plain multiply, streamed check
    begin
      int cnt;
      long_k = 16'hFFFF;
      long_c = 16'h0;
      long_bad = 0;
      long_run = 1'b1;
      @(negedge clk);
      mode = 2'b00; len = 17'd65536; scalar = long_k; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (done !== 1'b1 && cnt < 70000) begin
        @(negedge clk);
        cnt++;
      end
      check(cnt == 65538, "R9", 32'(cnt), 32'd65538);
      check(long_bad == 0, "R9", 32'(long_bad), 32'd0);
      check(result === 16'h0, "R9", {16'd0, result}, 32'd0);
      long_run = 1'b0;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule